// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Dual Line Enables

This block sits beside a small processor core and decides which interrupt request, if any, the core takes next. Every request line first crosses into the controller's clock domain through a synchronizer. A per-line mode bit then selects how the line raises its pending flag: on a rising edge, or on every cycle that the line is held high. A line can be taken only when three things hold together: a global enable, an enable driven by a rate-limiting scheduler, and an enable driven by software. The line's enable is the AND of the scheduler enable and the software enable. The scheduler and software therefore never write to one shared bit, and neither can undo what the other has set.

The core marks each instruction boundary with a strobe. On a strobe, the controller selects the lowest-numbered line that is eligible. In one clock edge it then raises a one-cycle take pulse, presents the line's binary index as the vector, clears that line's pending flag and drops the global enable. The core pushes its own context. When it later signals a return from interrupt, the global enable comes back on. Software can also discard any pending request through a write-one-to-clear input.

Top module: `irqc_top`

## Requirements
- R1: During and straight after reset, `pend` is all zeros, `gie` is 0, `take` is 0 and `vec` is 0.
- R2: A line whose `trig_mode` bit is 1 (edge) sets its `pend` bit on the third rising clock edge after its request rises. A request that is held high sets the bit only once. A line whose mode bit is 0 (level) sets its `pend` bit on every cycle that its synchronized request is high, again with a latency of three edges.
- R3: While `gie` is 0, `take` never rises, whatever is pending or enabled.
- R4: When more than one line is eligible, `vec` carries the binary index of the lowest-numbered eligible line.
- R5: A take is a `take` pulse that lasts exactly one cycle. On the same edge, `vec` is loaded, the chosen line's `pend` bit is cleared (unless a new trigger for that line arrives on that edge) and `gie` is cleared.
- R6: A line is eligible only when its `pend`, `sched_en` and `sw_en` bits are all 1. A pending line that is missing either enable is not taken and stays pending.
- R7: A trigger that arrives while a line is already pending is lost. One take consumes the request, and no second take follows from that line.
- R8: A `reti` pulse sets `gie` on the next edge. If a take happens on the same edge, the take wins and `gie` ends up 0.
- R9: A 1 on a `clr_pend` bit clears that `pend` bit on the next edge. A trigger on the same edge wins, and the bit stays 1.
- R10: A take happens only on an edge where `boundary` was high.
- R11: A level-mode line whose request is still high becomes pending again, even straight after a take or a software clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_req | input | NLINES | Raw request lines, asynchronous to `clk` |
| trig_mode | input | NLINES | Per-line trigger mode: 1 means edge, 0 means level |
| sched_en | input | NLINES | Per-line enable driven by the rate-limiting scheduler |
| sw_en | input | NLINES | Per-line enable driven by software |
| clr_pend | input | NLINES | Write-one-to-clear strobes for the pending bits |
| boundary | input | 1 | Instruction-boundary strobe from the core |
| reti | input | 1 | Return-from-interrupt strobe from the core |
| take | output | 1 | One-cycle pulse when an interrupt is taken |
| vec | output | VEC_W | Index of the line that was taken |
| gie | output | 1 | Global interrupt enable state |
| pend | output | NLINES | Pending bits |

## Verification
The bench builds the controller with eight lines and a two-stage synchronizer. With eight lines, a single vector can exercise the ordering of the lowest, middle and highest indices, and the bench can mix edge-mode and level-mode lines. The short synchronizer keeps the three-edge delay from a request to its pending bit short enough to count exactly. Because of that exact count, the bench can place a software clear, or a take, on the very edge where a trigger lands.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_e;

  localparam int SYNC_MIN = 2;

endpackage

// File: rtl/irqc_line_sync.sv
module irqc_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  input  logic mode,
  output logic hit
);
  import irqc_pkg::*;

  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sr;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr     <= '0;
      last_q <= 1'b0;
    end else begin
      sr     <= {sr[STAGES-2:0], raw};
      last_q <= sr[TOP];
    end
  end

  always_comb begin
    if (mode == logic'(TRIG_EDGE)) hit = sr[TOP] & ~last_q;
    else                           hit = sr[TOP];
  end

endmodule

// File: rtl/irqc_pend_bank.sv
module irqc_pend_bank #(
  parameter int NLINES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] set_v,
  input  logic [NLINES-1:0] w1c_v,
  input  logic [NLINES-1:0] take_v,
  output logic [NLINES-1:0] pend
);

  logic [NLINES-1:0] pend_q;

  genvar g;
  generate
    for (g = 0; g < NLINES; g++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)             pend_q[g] <= 1'b0;
        else if (set_v[g])   pend_q[g] <= 1'b1;
        else if (w1c_v[g] || take_v[g]) pend_q[g] <= 1'b0;
      end
    end
  endgenerate

  assign pend = pend_q;

endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
  parameter int NLINES = 8,
  parameter int VEC_W  = 3
) (
  input  logic [NLINES-1:0] elig,
  output logic              any,
  output logic [VEC_W-1:0]  idx,
  output logic [NLINES-1:0] onehot
);

  always_comb begin
    any    = 1'b0;
    idx    = '0;
    onehot = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (elig[i]) begin
        any    = 1'b1;
        idx    = VEC_W'(i);
        onehot = NLINES'(1) << i;
      end
    end
  end

endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int NLINES      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int VEC_W       = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] irq_req,
  input  logic [NLINES-1:0] trig_mode,
  input  logic [NLINES-1:0] sched_en,
  input  logic [NLINES-1:0] sw_en,
  input  logic [NLINES-1:0] clr_pend,
  input  logic              boundary,
  input  logic              reti,
  output logic              take,
  output logic [VEC_W-1:0]  vec,
  output logic              gie,
  output logic [NLINES-1:0] pend
);
  import irqc_pkg::*;

  localparam int STG = (SYNC_STAGES < SYNC_MIN) ? SYNC_MIN : SYNC_STAGES;

  logic [NLINES-1:0] hit_v;
  logic [NLINES-1:0] pend_v;
  logic [NLINES-1:0] elig_v;
  logic [NLINES-1:0] sel_oh;
  logic [NLINES-1:0] take_clr;
  logic [VEC_W-1:0]  sel_idx;
  logic              sel_any;
  logic              fire;
  logic              gie_q;
  logic              take_q;
  logic [VEC_W-1:0]  vec_q;

  genvar g;
  generate
    for (g = 0; g < NLINES; g++) begin : g_line
      irqc_line_sync #(.STAGES(STG)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  (irq_req[g]),
        .mode (trig_mode[g]),
        .hit  (hit_v[g])
      );
    end
  endgenerate

  irqc_pend_bank #(.NLINES(NLINES)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .set_v  (hit_v),
    .w1c_v  (clr_pend),
    .take_v (take_clr),
    .pend   (pend_v)
  );

  assign elig_v = pend_v & sched_en & sw_en;

  irqc_pick #(.NLINES(NLINES), .VEC_W(VEC_W)) u_pick (
    .elig   (elig_v),
    .any    (sel_any),
    .idx    (sel_idx),
    .onehot (sel_oh)
  );

  assign fire     = boundary & gie_q & sel_any;
  assign take_clr = fire ? sel_oh : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q  <= 1'b0;
      take_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      take_q <= fire;
      if (fire) vec_q <= sel_idx;
      if (fire)      gie_q <= 1'b0;
      else if (reti) gie_q <= 1'b1;
    end
  end

  assign take = take_q;
  assign vec  = vec_q;
  assign gie  = gie_q;
  assign pend = pend_v;

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int NLINES = 8,
  parameter int VEC_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [NLINES-1:0] sched_en,
  input logic [NLINES-1:0] sw_en,
  input logic              boundary,
  input logic              reti,
  input logic              take,
  input logic [VEC_W-1:0]  vec,
  input logic              gie,
  input logic [NLINES-1:0] pend
);

  logic [NLINES-1:0] elig_q;
  logic [NLINES-1:0] below;
  logic              gie_q;
  logic              bnd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      elig_q <= '0;
      gie_q  <= 1'b0;
      bnd_q  <= 1'b0;
    end else begin
      elig_q <= pend & sched_en & sw_en;
      gie_q  <= gie;
      bnd_q  <= boundary;
    end
  end

  always_comb begin
    below = '0;
    for (int i = 0; i < NLINES; i++) if (i < int'(vec)) below[i] = 1'b1;
  end

  // R5
  take_pulse_chk: assert property (@(posedge clk) disable iff (rst) take |=> !take);
  // R5
  take_drops_gie_chk: assert property (@(posedge clk) disable iff (rst) take |-> !gie);
  // R3
  gie_gate_chk: assert property (@(posedge clk) disable iff (rst) take |-> gie_q);
  // R10
  boundary_gate_chk: assert property (@(posedge clk) disable iff (rst) take |-> bnd_q);
  // R6
  eligible_pick_chk: assert property (@(posedge clk) disable iff (rst) take |-> elig_q[vec]);
  // R4
  lowest_first_chk: assert property (@(posedge clk) disable iff (rst) take |-> ((elig_q & below) == '0));
  // R8
  reti_restore_chk: assert property (@(posedge clk) disable iff (rst) reti |=> (take || gie));

endmodule

bind irqc_top irqc_chk #(.NLINES(NLINES), .VEC_W(VEC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sched_en (sched_en),
  .sw_en    (sw_en),
  .boundary (boundary),
  .reti     (reti),
  .take     (take),
  .vec      (vec),
  .gie      (gie),
  .pend     (pend)
);

// File: tb/sim_irqc_top.sv
module sim_irqc_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int VW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  irq_req, trig_mode, sched_en, sw_en, clr_pend;
  logic          boundary, reti;
  logic          take;
  logic [VW-1:0] vec;
  logic          gie;
  logic [N-1:0]  pend;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqc_top #(.NLINES(N), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .irq_req(irq_req), .trig_mode(trig_mode),
    .sched_en(sched_en), .sw_en(sw_en), .clr_pend(clr_pend),
    .boundary(boundary), .reti(reti), .take(take), .vec(vec),
    .gie(gie), .pend(pend)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic arm;
    reti = 1'b1; step(1); reti = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; step(3); rst = 1'b0;
    check("R1 pend", int'(pend), 0);
    check("R1 gie", int'(gie), 0);
    check("R1 take", int'(take), 0);
    check("R1 vec", int'(vec), 0);
    step(1);
    check("R1 take after release", int'(take), 0);
  endtask

  task automatic t_edge_pend;
    irq_req[3] = 1'b1;
    step(2);
    check("R2 edge not yet", int'(pend[3]), 0);
    step(1);
    check("R2 edge pending", int'(pend[3]), 1);
  endtask

  task automatic t_boundary_take;
    arm();
    check("R8 reti sets gie", int'(gie), 1);
    step(3);
    check("R10 no take off boundary", int'(take), 0);
    boundary = 1'b1; step(1); boundary = 1'b0;
    check("R5 take", int'(take), 1);
    check("R5 vec", int'(vec), 3);
    check("R5 pend cleared", int'(pend[3]), 0);
    check("R5 gie cleared", int'(gie), 0);
    step(1);
    check("R5 single pulse", int'(take), 0);
    check("R2 held edge no re-pend", int'(pend[3]), 0);
    irq_req[3] = 1'b0;
  endtask

  task automatic t_gie_block;
    irq_req[1] = 1'b1; step(3); irq_req[1] = 1'b0;
    check("R2 line1 pending", int'(pend[1]), 1);
    boundary = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step(1);
      check("R3 no take gie clear", int'(take), 0);
    end
    reti = 1'b1; step(1); reti = 1'b0;
    check("R8 gie set", int'(gie), 1);
    check("R8 no take yet", int'(take), 0);
    step(1); boundary = 1'b0;
    check("R5 take after reti", int'(take), 1);
    check("R5 vec line1", int'(vec), 1);
    check("R5 gie off", int'(gie), 0);
  endtask

  task automatic t_priority;
    irq_req[2] = 1'b1; irq_req[5] = 1'b1; irq_req[6] = 1'b1;
    step(3);
    irq_req = '0;
    check("R2 three pending", int'(pend), 8'h64);
    arm(); boundary = 1'b1; step(1); boundary = 1'b0;
    check("R4 first pick", int'(vec), 2);
    arm(); boundary = 1'b1; step(1); boundary = 1'b0;
    check("R4 second pick", int'(vec), 5);
    arm(); boundary = 1'b1; step(1); boundary = 1'b0;
    check("R4 third pick", int'(vec), 6);
    check("R4 all drained", int'(pend), 0);
    step(2);
  endtask

  task automatic t_dual_enable;
    irq_req[0] = 1'b1; irq_req[4] = 1'b1;
    step(3);
    irq_req = '0;
    sw_en[0] = 1'b0;
    arm(); boundary = 1'b1; step(1); boundary = 1'b0;
    check("R6 sw_en off skips line0", int'(vec), 4);
    sched_en[0] = 1'b0; sw_en[0] = 1'b1;
    arm(); boundary = 1'b1;
    step(1);
    check("R6 sched_en off no take", int'(take), 0);
    step(1);
    check("R6 sched_en off no take again", int'(take), 0);
    check("R6 line0 still pending", int'(pend[0]), 1);
    sched_en[0] = 1'b1;
    step(1); boundary = 1'b0;
    check("R6 both enables take", int'(take), 1);
    check("R6 vec line0", int'(vec), 0);
  endtask

  task automatic t_lost;
    irq_req[7] = 1'b1; step(2); irq_req[7] = 1'b0; step(2);
    irq_req[7] = 1'b1; step(2); irq_req[7] = 1'b0; step(4);
    arm(); boundary = 1'b1; step(1); boundary = 1'b0;
    check("R7 first take", int'(take), 1);
    check("R7 vec7", int'(vec), 7);
    check("R7 nothing left", int'(pend[7]), 0);
    arm(); boundary = 1'b1;
    step(1);
    check("R7 no second take", int'(take), 0);
    step(1); boundary = 1'b0;
    check("R7 still none", int'(take), 0);
  endtask

  task automatic t_w1c;
    irq_req[1] = 1'b1; step(3); irq_req[1] = 1'b0;
    check("R9 pending before clear", int'(pend[1]), 1);
    clr_pend[1] = 1'b1; step(1); clr_pend[1] = 1'b0;
    check("R9 cleared", int'(pend[1]), 0);
    irq_req[2] = 1'b1; step(2);
    clr_pend[2] = 1'b1; step(1); clr_pend[2] = 1'b0;
    check("R9 set wins over clear", int'(pend[2]), 1);
    irq_req[2] = 1'b0;
    clr_pend[2] = 1'b1; step(1); clr_pend[2] = 1'b0;
    check("R9 clear after", int'(pend[2]), 0);
  endtask

  task automatic t_level;
    trig_mode[5] = 1'b0;
    irq_req[5] = 1'b1; step(3);
    check("R2 level pending", int'(pend[5]), 1);
    clr_pend[5] = 1'b1; step(1); clr_pend[5] = 1'b0;
    check("R11 re-pend after clear", int'(pend[5]), 1);
    boundary = 1'b1; step(1); boundary = 1'b0;
    check("R11 take level", int'(vec), 5);
    check("R11 re-pend after take", int'(pend[5]), 1);
    irq_req[5] = 1'b0; step(3);
    clr_pend[5] = 1'b1; step(1); clr_pend[5] = 1'b0;
    check("R2 level low cleared", int'(pend[5]), 0);
    step(2);
    check("R2 level low stays clear", int'(pend[5]), 0);
    trig_mode[5] = 1'b1;
  endtask

  task automatic t_reti_vs_take;
    irq_req[6] = 1'b1; step(3); irq_req[6] = 1'b0;
    arm();
    boundary = 1'b1; reti = 1'b1; step(1); boundary = 1'b0; reti = 1'b0;
    check("R8 take beats reti", int'(take), 1);
    check("R8 gie off", int'(gie), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; irq_req = '0; trig_mode = '1; sched_en = '1; sw_en = '1;
    clr_pend = '0; boundary = 1'b0; reti = 1'b0;
    step(1);
    t_reset();
    t_edge_pend();
    t_boundary_take();
    t_gie_block();
    t_priority();
    t_dual_enable();
    t_lost();
    t_w1c();
    t_level();
    t_reti_vs_take();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule